// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of an audio controller into one 32-bit status word and turns that word into a single interrupt request. Low status bits mirror the buffer-completion flag of each DMA stream. The first half of the streams are capture streams and the second half are playback streams. One controller bit merges the response-ring events with any codec state change that software has enabled for wake-up. The top bit is the global summary, which is the status masked by the per-source enables.

Software works through a small register port with four word addresses. The port holds the control word, the wake-enable mask and the write-one-to-clear codec state-change vector, and it also reads back the live status word. The request leaves the block in one of two forms. The first is a registered level on the wired interrupt line. The second, used when message-signalled mode is selected, is a one-cycle message pulse. A two-state machine follows the computed request. In `IRQ_QUIET` no request is pending. It moves to `IRQ_RAISED` on the transition *raise*, taken when the request becomes true. It returns on the transition *drop*, taken when the request becomes false. A message pulse is sent only on *raise*, and only when message mode is selected.

Top module: `snd_irq_merge`

## Requirements
- R1: Status bit i (read at address 3) equals `stream_done_i[i]` for each stream i in 0..NUM_STREAMS-1; status bits NUM_STREAMS..29 read as zero.
- R2: Status bit 30 is 1 exactly when `ring_irq_i` is 1, or `ring_ovr_i` is 1, or any state-change bit is 1 whose wake-enable bit is also 1.
- R3: Status bit 31 is 1 exactly when status bits 30..0 ANDed with control bits 30..0 are nonzero.
- R4: `irq_level_o` is 1 one cycle after a cycle in which status bit 31 and control bit 31 were both 1 and `msi_mode_i` was 0; otherwise it is 0.
- R5: When `msi_mode_i` is 1, `msg_pulse_o` is 1 for exactly one cycle after the machine takes *raise*. A request that stays high sends no further pulse, and *drop* sends none. `msg_pulse_o` is 0 whenever `msi_mode_i` was 0.
- R6: A write to address 0 (control) stores only bits 31, 30 and NUM_STREAMS-1..0 of the data; all other bits read back as zero.
- R7: A write to address 1 (wake enable) stores only bits NUM_CODECS-1..0.
- R8: The state-change vector at address 2 sets each bit i when `codec_evt_i[i]` is 1. A write to address 2 clears the bits written as 1 and leaves the others unchanged. A new event wins over a clear in the same cycle.
- R9: A one-cycle `ctrl_reset_i` clears control and wake enable, loads the state-change vector with `codec_present_i | codec_evt_i`, and ignores any register write in that cycle. The request is then recomputed from the new values.
- R10: A write to address 3 (status) has no effect on any register.
- R11: After `rst_n` is asserted, every register reads zero and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_mode_i | input | 1 | 1 selects message pulses, 0 selects the wired level |
| stream_done_i | input | NUM_STREAMS | Buffer-completion flag per stream |
| ring_irq_i | input | 1 | Response-ring interrupt flag |
| ring_ovr_i | input | 1 | Response-ring overrun flag |
| codec_evt_i | input | NUM_CODECS | Codec state-change event per codec address |
| codec_present_i | input | NUM_CODECS | Codec addresses attached, loaded on controller reset |
| ctrl_reset_i | input | 1 | Controller reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 wake enable, 2 state change, 3 status |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 32 | Combinational read data |
| irq_level_o | output | 1 | Registered wired interrupt level |
| msg_pulse_o | output | 1 | One-cycle message request |

## Verification
The bench builds the block with its defaults: eight streams and fifteen codec addresses. With these values every stream bit and every state-change bit is driven, and the control mask has its full width. Sparse random stream flags and random control words make the summary bit toggle often. Switching between the two interrupt modes then produces pulses, held requests and requests that enter message mode while already active. Directed cases add controller reset, clears that collide with new events, and writes to the read-only status address.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;

    localparam int WORD_W   = 32;
    localparam int CTL_BIT  = 30;   // controller event summary
    localparam int GLB_BIT  = 31;   // global summary / global enable

    typedef enum logic [1:0] {
        ADR_CTRL   = 2'd0,
        ADR_WAKE   = 2'd1,
        ADR_SCHG   = 2'd2,
        ADR_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/snd_irq_regs.sv
module snd_irq_regs
    import snd_irq_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_reset_i,
    input  logic [NUM_CODECS-1:0] codec_evt_i,
    input  logic [NUM_CODECS-1:0] codec_present_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_addr_i,
    input  logic [WORD_W-1:0]     wr_data_i,
    output logic [WORD_W-1:0]     ctrl_q,
    output logic [WORD_W-1:0]     wake_q,
    output logic [WORD_W-1:0]     schg_q
);

    localparam logic [WORD_W-1:0] STREAM_MASK = (WORD_W'(1) << NUM_STREAMS) - WORD_W'(1);
    localparam logic [WORD_W-1:0] CTRL_WMASK  = (WORD_W'(1) << GLB_BIT) | (WORD_W'(1) << CTL_BIT)
                                               | STREAM_MASK;
    localparam logic [WORD_W-1:0] CODEC_MASK  = (WORD_W'(1) << NUM_CODECS) - WORD_W'(1);

    logic [WORD_W-1:0] evt_w;
    logic [WORD_W-1:0] clr_w;
    logic              wr_ctrl, wr_wake, wr_schg;

    always_comb begin
        evt_w   = WORD_W'(codec_evt_i);
        wr_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);
        wr_wake = wr_en_i && (wr_addr_i == ADR_WAKE);
        wr_schg = wr_en_i && (wr_addr_i == ADR_SCHG);
        clr_w   = wr_schg ? (wr_data_i & CODEC_MASK) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wake_q <= '0;
            schg_q <= '0;
        end else if (ctrl_reset_i) begin
            ctrl_q <= '0;
            wake_q <= '0;
            schg_q <= WORD_W'(codec_present_i) | evt_w;
        end else begin
            if (wr_ctrl) ctrl_q <= wr_data_i & CTRL_WMASK;
            if (wr_wake) wake_q <= wr_data_i & CODEC_MASK;
            schg_q <= (schg_q & ~clr_w) | evt_w;
        end
    end

endmodule

// File: rtl/snd_irq_status.sv
module snd_irq_status
    import snd_irq_pkg::*;
#(
    parameter int NUM_STREAMS = 8
) (
    input  logic [NUM_STREAMS-1:0] stream_done_i,
    input  logic                   ring_irq_i,
    input  logic                   ring_ovr_i,
    input  logic [WORD_W-1:0]      ctrl_i,
    input  logic [WORD_W-1:0]      wake_i,
    input  logic [WORD_W-1:0]      schg_i,
    output logic [WORD_W-1:0]      status_o
);

    logic [CTL_BIT-1:0] stream_bits;
    logic               ctl_evt;
    logic [GLB_BIT-1:0] low_bits;

    for (genvar i = 0; i < CTL_BIT; i++) begin : g_bit
        if (i < NUM_STREAMS) begin : g_used
            assign stream_bits[i] = stream_done_i[i];
        end else begin : g_idle
            assign stream_bits[i] = 1'b0;
        end
    end

    always_comb begin
        ctl_evt  = ring_irq_i | ring_ovr_i | (|(schg_i & wake_i));
        low_bits = {ctl_evt, stream_bits};
        status_o = {|(low_bits & ctrl_i[GLB_BIT-1:0]), low_bits};
    end

endmodule

// File: rtl/snd_irq_fsm.sv
module snd_irq_fsm
    import snd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic msi_mode_i,
    output logic level_o,
    output logic pulse_o
);

    irq_state_e state_q, state_d;
    logic       raise_w;

    always_comb begin
        state_d = state_q;
        raise_w = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                if (req_i) begin
                    state_d = IRQ_RAISED;   // raise
                    raise_w = 1'b1;
                end
            end
            IRQ_RAISED: begin
                if (!req_i) state_d = IRQ_QUIET;  // drop
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            level_o <= req_i && !msi_mode_i;
            pulse_o <= raise_w && msi_mode_i;
        end
    end

endmodule

// File: rtl/snd_irq_merge.sv
module snd_irq_merge
    import snd_irq_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   msi_mode_i,
    input  logic [NUM_STREAMS-1:0] stream_done_i,
    input  logic                   ring_irq_i,
    input  logic                   ring_ovr_i,
    input  logic [NUM_CODECS-1:0]  codec_evt_i,
    input  logic [NUM_CODECS-1:0]  codec_present_i,
    input  logic                   ctrl_reset_i,
    input  logic                   wr_en_i,
    input  logic [1:0]             wr_addr_i,
    input  logic [31:0]            wr_data_i,
    input  logic [1:0]             rd_addr_i,
    output logic [31:0]            rd_data_o,
    output logic                   irq_level_o,
    output logic                   msg_pulse_o
);

    logic [WORD_W-1:0] ctrl_q, wake_q, schg_q, status_w;
    logic              req_w;

    snd_irq_regs #(.NUM_STREAMS(NUM_STREAMS), .NUM_CODECS(NUM_CODECS)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_reset_i   (ctrl_reset_i),
        .codec_evt_i    (codec_evt_i),
        .codec_present_i(codec_present_i),
        .wr_en_i        (wr_en_i),
        .wr_addr_i      (wr_addr_i),
        .wr_data_i      (wr_data_i),
        .ctrl_q         (ctrl_q),
        .wake_q         (wake_q),
        .schg_q         (schg_q)
    );

    snd_irq_status #(.NUM_STREAMS(NUM_STREAMS)) u_status (
        .stream_done_i(stream_done_i),
        .ring_irq_i   (ring_irq_i),
        .ring_ovr_i   (ring_ovr_i),
        .ctrl_i       (ctrl_q),
        .wake_i       (wake_q),
        .schg_i       (schg_q),
        .status_o     (status_w)
    );

    assign req_w = status_w[GLB_BIT] && ctrl_q[GLB_BIT];

    snd_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_w),
        .msi_mode_i(msi_mode_i),
        .level_o   (irq_level_o),
        .pulse_o   (msg_pulse_o)
    );

    always_comb begin
        unique case (rd_addr_i)
            ADR_CTRL: rd_data_o = ctrl_q;
            ADR_WAKE: rd_data_o = wake_q;
            ADR_SCHG: rd_data_o = schg_q;
            default:  rd_data_o = status_w;
        endcase
    end

endmodule

// File: rtl/snd_irq_merge_chk.sv
module snd_irq_merge_chk #(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_mode_i,
    input logic [1:0]  rd_addr_i,
    input logic [31:0] rd_data_o,
    input logic [31:0] ctrl_q,
    input logic [31:0] status_w,
    input logic        irq_level_o,
    input logic        msg_pulse_o
);

    assert_level_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o |-> ($past(ctrl_q[31]) && $past(status_w[31]) && !$past(msi_mode_i)));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse_o |=> !msg_pulse_o);

    assert_pulse_needs_msi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse_o |-> ($past(msi_mode_i) && $past(ctrl_q[31]) && $past(status_w[31])));

    assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_pulse_o && irq_level_o));

    assert_ctrl_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd0) |-> (rd_data_o[29:NUM_STREAMS] == '0));

    assert_wake_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd1) |-> (rd_data_o[31:NUM_CODECS] == '0));

    assert_schg_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == 2'd2) |-> (rd_data_o[31:NUM_CODECS] == '0));

    assert_status_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[29:NUM_STREAMS] == '0);

endmodule

bind snd_irq_merge snd_irq_merge_chk #(.NUM_STREAMS(NUM_STREAMS), .NUM_CODECS(NUM_CODECS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msi_mode_i (msi_mode_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .ctrl_q     (ctrl_q),
    .status_w   (status_w),
    .irq_level_o(irq_level_o),
    .msg_pulse_o(msg_pulse_o)
);

// File: tb/snd_irq_merge_tb.sv
`timescale 1ns/1ps
module snd_irq_merge_tb;

    localparam int NS = 8;
    localparam int NC = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msi_mode_i = 1'b0;
    logic [NS-1:0] stream_done_i = '0;
    logic          ring_irq_i = 1'b0, ring_ovr_i = 1'b0;
    logic [NC-1:0] codec_evt_i = '0, codec_present_i = '0;
    logic          ctrl_reset_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_addr_i = '0;
    logic [31:0]   wr_data_i = '0;
    logic [1:0]    rd_addr_i = '0;
    logic [31:0]   rd_data_o;
    logic          irq_level_o, msg_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_ctrl, m_wake, m_schg;
    bit          m_act;

    always #10 clk = ~clk;

    snd_irq_merge #(.NUM_STREAMS(NS), .NUM_CODECS(NC)) u_dut (.*);

    function automatic logic [31:0] model_status();
        logic [31:0] s = '0;
        for (int i = 0; i < NS; i++) s[i] = stream_done_i[i];
        s[30] = ring_irq_i || ring_ovr_i || ((m_schg & m_wake) != 0);
        s[31] = ((s[30:0] & m_ctrl[30:0]) != 0);
        return s;
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_wake;
            2'd2:    return m_schg;
            default: return model_status();
        endcase
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs are set at a negedge; checks comb read, then clocks and checks outputs
    task automatic step();
        logic [31:0] sts, clrm, ctrl_mask;
        bit lvl, e_lvl, e_pls;
        string tag;
        #1;
        case (rd_addr_i)
            2'd0: tag = "R6 ctrl readback";
            2'd1: tag = "R7 wake readback";
            2'd2: tag = "R8 state-change readback";
            default: tag = "R1 R2 R3 status word";
        endcase
        check(rd_data_o, model_read(rd_addr_i), tag);
        sts   = model_status();
        lvl   = sts[31] && m_ctrl[31];
        e_lvl = lvl && !msi_mode_i;
        e_pls = lvl && msi_mode_i && !m_act;
        m_act = lvl;
        ctrl_mask = 32'hC000_0000 | ((32'h1 << NS) - 1);
        if (ctrl_reset_i) begin
            m_ctrl = '0; m_wake = '0;
            m_schg = 32'(codec_present_i) | 32'(codec_evt_i);
        end else begin
            clrm = (wr_en_i && wr_addr_i == 2'd2) ? (wr_data_i & ((32'h1 << NC) - 1)) : '0;
            if (wr_en_i && wr_addr_i == 2'd0) m_ctrl = wr_data_i & ctrl_mask;
            if (wr_en_i && wr_addr_i == 2'd1) m_wake = wr_data_i & ((32'h1 << NC) - 1);
            m_schg = (m_schg & ~clrm) | 32'(codec_evt_i);
        end
        @(posedge clk);
        @(negedge clk);
        check(32'(irq_level_o), 32'(e_lvl), "R4 irq level");
        check(32'(msg_pulse_o), 32'(e_pls), "R5 message pulse");
    endtask

    task automatic idle_inputs();
        wr_en_i = 0; ctrl_reset_i = 0; codec_evt_i = '0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, logic [1:0] ra);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra;
        step();
        idle_inputs();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctrl = '0; m_wake = '0; m_schg = '0; m_act = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr_i = 2'(a); #1;
            check(rd_data_o, 32'h0, "R11 register zero in reset");
        end
        check(32'(irq_level_o), 0, "R11 level low in reset");
        check(32'(msg_pulse_o), 0, "R11 pulse low in reset");
        rst_n = 1;
        @(negedge clk);

        // R6: control write mask
        wr(2'd0, 32'hFFFF_FFFF, 2'd0);
        rd_addr_i = 2'd0; #1; check(rd_data_o, 32'hC000_00FF, "R6 control mask");
        // R7: wake mask
        wr(2'd1, 32'hFFFF_FFFF, 2'd1);
        rd_addr_i = 2'd1; #1; check(rd_data_o, 32'h0000_7FFF, "R7 wake mask");
        // R8: event sets, W1C clears, event beats clear
        codec_evt_i = 15'h0005; step(); idle_inputs();
        wr(2'd2, 32'h0000_0001, 2'd2);
        rd_addr_i = 2'd2; #1; check(rd_data_o, 32'h4, "R8 clear one bit");
        codec_evt_i = 15'h0004; wr(2'd2, 32'h4, 2'd2);
        rd_addr_i = 2'd2; #1; check(rd_data_o, 32'h4, "R8 event beats clear");
        // R10: status writes ignored
        wr(2'd3, 32'hFFFF_FFFF, 2'd0);
        rd_addr_i = 2'd0; #1; check(rd_data_o, 32'hC000_00FF, "R10 ctrl unchanged");
        rd_addr_i = 2'd2; #1; check(rd_data_o, 32'h4, "R10 state-change unchanged");
        // R5: held request in message mode pulses once
        wr(2'd2, 32'h7FFF, 2'd3);
        msi_mode_i = 1; stream_done_i = 8'h10;
        repeat (4) step();
        stream_done_i = '0; step(); step();
        stream_done_i = 8'h01; step(); step();
        msi_mode_i = 0; stream_done_i = '0; step();
        // R9: controller reset loads present codecs, clears enables, drops request
        codec_present_i = 15'h0003; ctrl_reset_i = 1; wr_en_i = 1;
        wr_addr_i = 2'd1; wr_data_i = 32'hFFFF; rd_addr_i = 2'd2;
        step(); idle_inputs();
        rd_addr_i = 2'd2; #1; check(rd_data_o, 32'h3, "R9 present codecs loaded");
        rd_addr_i = 2'd1; #1; check(rd_data_o, 32'h0, "R9 wake cleared, write ignored");
        // R2: wake enable routes state change to bit 30
        wr(2'd1, 32'h2, 2'd3);
        rd_addr_i = 2'd3; #1; check(rd_data_o & 32'h4000_0000, 32'h4000_0000, "R2 wake-enabled change");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            stream_done_i = NS'($urandom & $urandom & $urandom);
            ring_irq_i    = ($urandom % 8) == 0;
            ring_ovr_i    = ($urandom % 10) == 0;
            codec_evt_i   = NC'(((($urandom % 6) == 0) ? 1 : 0) << ($urandom % NC));
            codec_present_i = NC'($urandom);
            ctrl_reset_i  = ($urandom % 40) == 0;
            wr_en_i       = r[1:0] == 2'b00;
            wr_addr_i     = r[3:2];
            wr_data_i     = $urandom;
            rd_addr_i     = r[5:4];
            if (r[9:6] == 0) msi_mode_i = !msi_mode_i;
            step();
        end
        idle_inputs();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule